// File: doc/BRIEF.md
# Two-Section Decade Ripple Counter

This block is a four-bit counter made of two sections, each with its own clock. The low section is a single toggle stage that divides by two and drives the least significant output. The high section is a three-bit stage that divides by five. Each section advances only on the falling edge of its own clock, so the two can run separately. They can also be chained outside the block, one section's output feeding the other section's clock.

If the low output drives the high clock and the low clock is pulsed, the outputs run through a BCD decade from 0 to 9. If the high section's top bit drives the low clock and the high clock is pulsed, the outputs give a bi-quinary count. Two AND-gated controls act without a clock. One clears the whole counter. The other forces it to nine, and it wins when both are active.

Top module: `decade_ripple_counter`

## Requirements
- R1: `cnt_lsb` inverts on every falling edge of `tick_lo_n`, and a rising edge of `tick_lo_n` leaves it unchanged.
- R2: On each falling edge of `tick_hi_n`, `cnt_hi` steps 000, 001, 010, 011, 100 and then back to 000. It never holds a value above 100.
- R3: A clock edge of one section never changes the outputs of the other section.
- R4: When `clr_en_a` and `clr_en_b` are both 1, the outputs {cnt_hi, cnt_lsb} become 0000 at once, with no clock edge. Either input alone has no effect.
- R5: When `nine_en_a` and `nine_en_b` are both 1, {cnt_hi, cnt_lsb} becomes 1001 (cnt_hi = 100, cnt_lsb = 1) at once. Either input alone has no effect.
- R6: When the gated clear and the gated nine are both active, the outputs read 1001.
- R7: While a gated clear or a gated nine is active, falling clock edges are ignored. After release, the value is held, and the first falling edge counts on from it.
- R8: With `cnt_lsb` wired to `tick_hi_n` and `tick_lo_n` pulsed, {cnt_hi, cnt_lsb} runs 0, 1, …, 9 and then 0.
- R9: With `cnt_hi[2]` wired to `tick_lo_n` and `tick_hi_n` pulsed, the value {cnt_lsb, cnt_hi} runs from 0 through 1, 2, 3, 4, 8, 9, 10, 11, 12 and back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_lo_n | input | 1 | Clock of the divide-by-two section; counts on its falling edge |
| tick_hi_n | input | 1 | Clock of the divide-by-five section; counts on its falling edge |
| clr_en_a | input | 1 | First input of the gated asynchronous clear |
| clr_en_b | input | 1 | Second input of the gated asynchronous clear |
| nine_en_a | input | 1 | First input of the gated asynchronous preset-to-nine |
| nine_en_b | input | 1 | Second input of the gated asynchronous preset-to-nine |
| cnt_lsb | output | 1 | Divide-by-two output, bit 0 of the count |
| cnt_hi | output | 3 | Divide-by-five output, bits 3..1 of the count |

## Verification
Some properties are checked at every edge of the section clocks:
- the toggle of the low section;
- the range and the wrap of the five-state section;
- the forced values seen while a control is held, with the nine taking priority.

A flag records a forced interval between two edges, so these checks stay valid around clear and preset. Other behaviour only shows up in the bench scenarios:
- the controls act without a clock;
- a single gated input does nothing;
- the sections stay independent of each other;
- the two externally chained orders, BCD and bi-quinary, give the right sequences.

// File: rtl/decade_ripple_counter.sv
module decade_ripple_counter (
  input  logic       tick_lo_n,
  input  logic       tick_hi_n,
  input  logic       clr_en_a,
  input  logic       clr_en_b,
  input  logic       nine_en_a,
  input  logic       nine_en_b,
  output logic       cnt_lsb,
  output logic [2:0] cnt_hi
);

  logic do_clr, do_nine, do_any;
  logic touched_lo, touched_hi;

  assign do_clr  = clr_en_a & clr_en_b;
  assign do_nine = nine_en_a & nine_en_b;
  assign do_any  = do_clr | do_nine;

  always_ff @(negedge tick_lo_n or posedge do_clr or posedge do_nine) begin
    if (do_nine)     cnt_lsb <= 1'b1;
    else if (do_clr) cnt_lsb <= 1'b0;
    else             cnt_lsb <= ~cnt_lsb;
  end

  always_ff @(negedge tick_hi_n or posedge do_clr or posedge do_nine) begin
    if (do_nine)                cnt_hi <= 3'b100;
    else if (do_clr)            cnt_hi <= 3'b000;
    else if (cnt_hi >= 3'b100)  cnt_hi <= 3'b000;
    else                        cnt_hi <= cnt_hi + 3'd1;
  end

  always_ff @(negedge tick_lo_n or posedge do_any) begin
    if (do_any) touched_lo <= 1'b1;
    else        touched_lo <= 1'b0;
  end

  always_ff @(negedge tick_hi_n or posedge do_any) begin
    if (do_any) touched_hi <= 1'b1;
    else        touched_hi <= 1'b0;
  end

  AST_LSB_FLIP: assert property (@(negedge tick_lo_n) disable iff (do_any)
    !$isunknown(cnt_lsb) |=> touched_lo || (cnt_lsb != $past(cnt_lsb))); // R1

  AST_HI_RANGE: assert property (@(negedge tick_hi_n) disable iff (do_any)
    !$isunknown(cnt_hi) |-> cnt_hi <= 3'b100); // R2

  AST_HI_WRAP: assert property (@(negedge tick_hi_n) disable iff (do_any)
    (cnt_hi == 3'b100) |=> touched_hi || (cnt_hi == 3'b000)); // R2

  AST_HI_STEP: assert property (@(negedge tick_hi_n) disable iff (do_any)
    (cnt_hi < 3'b100) |=> touched_hi || (cnt_hi == $past(cnt_hi) + 3'd1)); // R2

  AST_CLR_HOLD: assert property (@(negedge tick_lo_n) disable iff (do_nine)
    do_clr |-> !cnt_lsb && cnt_hi == 3'b000); // R7

  AST_NINE_WINS: assert property (@(negedge tick_hi_n) disable iff (!do_clr)
    do_nine |-> cnt_lsb && cnt_hi == 3'b100); // R6

endmodule

// File: tb/decade_ripple_counter_bench.sv
module decade_ripple_counter_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ext_lo = 1'b1, ext_hi = 1'b1;
  logic ca = 1'b0, cb = 1'b0, na = 1'b0, nb = 1'b0;
  int   mode = 0;
  logic cnt_lsb;
  logic [2:0] cnt_hi;
  logic tick_lo_n, tick_hi_n;

  assign tick_lo_n = (mode == 2) ? cnt_hi[2] : ext_lo;
  assign tick_hi_n = (mode == 1) ? cnt_lsb   : ext_hi;

  decade_ripple_counter u_decade_ripple_counter (
    .tick_lo_n(tick_lo_n), .tick_hi_n(tick_hi_n),
    .clr_en_a(ca), .clr_en_b(cb), .nine_en_a(na), .nine_en_b(nb),
    .cnt_lsb(cnt_lsb), .cnt_hi(cnt_hi));

  int checks = 0, errors = 0;
  logic       m_lo;
  logic [2:0] m_hi;

  function automatic logic [2:0] hi_next(logic [2:0] h);
    return (h == 3'd4) ? 3'd0 : h + 3'd1;
  endfunction

  function automatic logic [3:0] bcd_next(logic [3:0] v);
    return (v == 4'd9) ? 4'd0 : v + 4'd1;
  endfunction

  function automatic logic [3:0] bq_next(logic [3:0] v);
    logic [2:0] h;
    logic l;
    h = hi_next(v[2:0]);
    l = (v[2:0] == 3'd4) ? ~v[3] : v[3];
    return {l, h};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic pulse_lo;
    @(posedge clk); ext_lo <= 1'b0;
    @(posedge clk); ext_lo <= 1'b1;
    settle();
  endtask

  task automatic pulse_hi;
    @(posedge clk); ext_hi <= 1'b0;
    @(posedge clk); ext_hi <= 1'b1;
    settle();
  endtask

  task automatic set_ctl(logic a, logic b, logic c, logic d);
    @(posedge clk); ca <= a; cb <= b; na <= c; nb <= d;
    settle();
  endtask

  task automatic cmp(string req);
    check(req, {cnt_hi, cnt_lsb}, {m_hi, m_lo});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    settle();
    set_ctl(1, 1, 0, 0); m_lo = 0; m_hi = 0; cmp("R4 clear");
    set_ctl(0, 0, 0, 0); cmp("R4 release");

    pulse_lo(); m_lo = 1; cmp("R1 fall");
    @(posedge clk); ext_lo <= 1'b0; settle(); m_lo = 0;
    check("R1 mid", {cnt_hi, cnt_lsb}, {m_hi, m_lo});
    @(posedge clk); ext_lo <= 1'b1; settle();
    check("R1 rise ignored", {cnt_hi, cnt_lsb}, {m_hi, m_lo});
    for (int i = 0; i < 6; i++) begin pulse_hi(); m_hi = hi_next(m_hi); cmp("R2 step"); end
    pulse_lo(); m_lo = ~m_lo; cmp("R3 lo only");

    set_ctl(1, 0, 0, 0); cmp("R4 single clr");
    set_ctl(0, 1, 0, 0); cmp("R4 single clr b");
    set_ctl(0, 0, 1, 0); cmp("R5 single nine");
    set_ctl(0, 0, 0, 1); cmp("R5 single nine b");
    @(posedge clk); na <= 1'b1; nb <= 1'b1;
    #1; m_lo = 1; m_hi = 4;
    check("R5 async nine", {cnt_hi, cnt_lsb}, 4'b1001);
    settle();
    set_ctl(1, 1, 1, 1); cmp("R6 both");
    pulse_lo(); pulse_hi(); cmp("R7 edges ignored while nine");
    set_ctl(0, 0, 0, 0); cmp("R7 hold after release");
    pulse_hi(); m_hi = 0; pulse_lo(); m_lo = 0; cmp("R7 resume from nine");
    pulse_lo(); m_lo = 1;
    @(posedge clk); ca <= 1'b1; cb <= 1'b1;
    #1; check("R4 async clear", {cnt_hi, cnt_lsb}, 4'b0000);
    m_lo = 0; m_hi = 0;
    settle();
    pulse_lo(); pulse_hi(); cmp("R7 edges ignored while clear");
    set_ctl(0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: begin pulse_lo(); m_lo = ~m_lo; cmp("R1 random"); end
        2, 3: begin pulse_hi(); m_hi = hi_next(m_hi); cmp("R2 random"); end
        4: begin
          logic a, b;
          a = 1'($urandom_range(0, 1)); b = 1'($urandom_range(0, 1));
          set_ctl(a, b, 0, 0);
          if (a & b) begin m_lo = 0; m_hi = 0; end
          cmp("R4 random");
          set_ctl(0, 0, 0, 0);
        end
        default: begin
          logic a, b;
          a = 1'($urandom_range(0, 1)); b = 1'($urandom_range(0, 1));
          set_ctl(0, 0, a, b);
          if (a & b) begin m_lo = 1; m_hi = 4; end
          cmp("R5 random");
          set_ctl(0, 0, 0, 0);
        end
      endcase
    end

    set_ctl(1, 1, 0, 0); mode = 1; settle();
    set_ctl(0, 0, 0, 0);
    begin
      logic [3:0] v = 4'd0;
      for (int i = 0; i < 10; i++) begin
        pulse_lo(); v = bcd_next(v);
        check("R8 bcd", {cnt_hi, cnt_lsb}, v);
      end
    end

    set_ctl(1, 1, 0, 0); mode = 2; settle();
    set_ctl(0, 0, 0, 0);
    begin
      logic [3:0] v = 4'd0;
      for (int i = 0; i < 10; i++) begin
        pulse_hi(); v = bq_next(v);
        check("R9 biquinary", {cnt_lsb, cnt_hi}, v);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule